// File: doc/BRIEF.md
# Multi-cycle processor sequencing controller

This block is the control unit of a multi-cycle processor datapath. It holds a 4-bit state register. Each instruction runs as a sequence of states that starts at instruction fetch, passes through decode, and then follows a path of its own. The path depends on the instruction class: register-register ALU operation, OR with an immediate, load word, store word, or branch-if-equal. Every control point that the datapath needs is a Moore function of the current state. The control points are the register enables, the multiplexer selects, the register-file write, the data-memory strobes and the ALU function. A transfer selected in a state happens at the clock edge that leaves that state.

The datapath feeds three inputs back to the block: the opcode and the function field, both taken from its instruction register, and the operand-equality flag. The block reads the opcode and the equality flag only in the decode state. It reads the function field only in the register-register execute state. Branches take 3 cycles. Register-register, OR-immediate and store take 4. Loads take 5. Any other opcode advances the program counter by 4 and goes back to fetch.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `phase` is 4'b0000. In that fetch state only `imem_rd` and `ir_load` are 1. Every other control output is 0.
- R2: Fetch (0000) is always followed by decode (0001). In decode only `a_load` and `b_load` are 1.
- R3: In decode the next state is chosen from `opcode` as follows: 6'h00 goes to 0100, 6'h0D to 0110, 6'h23 to 1000 and 6'h2B to 1011. Opcode 6'h04 goes to 0010 when `eq_flag` is 1 and to 0011 when it is 0.
- R4: In register-register state 0100, `r_load` is 1, `alu_imm` is 0 and `alu_fn` equals `funct`. The next state is 0101. State 0101 asserts `reg_we`, `dst_rd`=1 and `pc_load` with `pc_src`=0, and it returns to 0000.
- R5: In OR-immediate state 0110, `r_load` is 1, `alu_imm` is 1, `ext_sign` is 0 and `alu_fn` is 6'h25. The next state is 0111. State 0111 asserts `reg_we` with `dst_rd`=0, plus `pc_load` with `pc_src`=0, and it returns to 0000.
- R6: The load path runs 1000, then 1001, then 1010. State 1000 asserts `r_load`, `alu_imm`, `ext_sign` and `alu_fn`=6'h20. State 1001 asserts `dmem_rd` and `m_load`. State 1010 asserts `reg_we`, `wb_mem` and `pc_load` with `dst_rd`=0 and `pc_src`=0.
- R7: The store path runs 1011, then 1100. State 1011 drives the same address computation as 1000. State 1100 asserts `dmem_wr` and `pc_load` with `pc_src`=0, and it returns to 0000.
- R8: Taken-branch state 0010 asserts `pc_load` with `pc_src`=1. Not-taken state 0011 asserts `pc_load` with `pc_src`=0. Both return to 0000.
- R9: Any opcode not listed in R3 goes from decode to 0011 and then to 0000.
- R10: Changes to `opcode` or `eq_flag` after the decode state do not change the remaining states of the instruction or their outputs.
- R11: Counted from fetch to the next fetch, an instruction takes 3 cycles for a branch or an unknown opcode, 4 for register-register, OR-immediate and store, and 5 for load.
- R12: In every state at most one of `reg_we`, `dmem_rd` and `dmem_wr` is 1. `pc_load` is 1 only in the last state of an instruction.
- R13: Driving `rst_n` low partway through an instruction sets `phase` to 0000 at once, and fetch starts again after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 6 | Opcode field of the instruction register |
| funct | input | 6 | Function field of the instruction register |
| eq_flag | input | 1 | Operand-equality flag from the datapath |
| phase | output | 4 | Current state encoding |
| imem_rd | output | 1 | Instruction memory read |
| ir_load | output | 1 | Instruction register enable |
| a_load | output | 1 | Operand A register enable |
| b_load | output | 1 | Operand B register enable |
| r_load | output | 1 | ALU result register enable |
| m_load | output | 1 | Memory data register enable |
| pc_load | output | 1 | Program counter enable |
| pc_src | output | 1 | PC source: 0 = PC+4, 1 = PC+4+offset |
| dst_rd | output | 1 | Register destination: 1 = rd, 0 = rt |
| reg_we | output | 1 | Register file write |
| ext_sign | output | 1 | Immediate extension: 1 = sign, 0 = zero |
| alu_imm | output | 1 | ALU second operand: 1 = immediate, 0 = B |
| alu_fn | output | 6 | ALU function code |
| dmem_rd | output | 1 | Data memory read |
| dmem_wr | output | 1 | Data memory write |
| wb_mem | output | 1 | Write-back source: 1 = memory data, 0 = ALU result |

## Verification
The assertions assume that `opcode` holds the value the datapath's instruction register had during decode. The dispatch property samples `opcode` at the decode edge and nowhere else. Outside decode the assertions check only properties of the state sequence and make no claim about the inputs. The stimulus sets `opcode`, `funct` and `eq_flag` before each fetch. After decode it changes them on purpose, so that any later use of those inputs shows up as a path or output mismatch at the ports.

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm #(
  parameter logic [5:0] OP_REG  = 6'h00,
  parameter logic [5:0] OP_ORI  = 6'h0D,
  parameter logic [5:0] OP_LOAD = 6'h23,
  parameter logic [5:0] OP_STOR = 6'h2B,
  parameter logic [5:0] OP_BEQ  = 6'h04,
  parameter logic [5:0] FN_ADD  = 6'h20,
  parameter logic [5:0] FN_OR   = 6'h25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  input  logic       eq_flag,
  output logic [3:0] phase,
  output logic       imem_rd,
  output logic       ir_load,
  output logic       a_load,
  output logic       b_load,
  output logic       r_load,
  output logic       m_load,
  output logic       pc_load,
  output logic       pc_src,
  output logic       dst_rd,
  output logic       reg_we,
  output logic       ext_sign,
  output logic       alu_imm,
  output logic [5:0] alu_fn,
  output logic       dmem_rd,
  output logic       dmem_wr,
  output logic       wb_mem
);

  typedef enum logic [3:0] {
    S_FETCH  = 4'b0000,
    S_DECODE = 4'b0001,
    S_BR_TK  = 4'b0010,
    S_SEQ    = 4'b0011,
    S_RR_EX  = 4'b0100,
    S_RR_WB  = 4'b0101,
    S_OI_EX  = 4'b0110,
    S_OI_WB  = 4'b0111,
    S_LD_AD  = 4'b1000,
    S_LD_MEM = 4'b1001,
    S_LD_WB  = 4'b1010,
    S_ST_AD  = 4'b1011,
    S_ST_MEM = 4'b1100
  } state_t;

  state_t state, state_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_FETCH;
    else        state <= state_nx;
  end

  always_comb begin
    state_nx = S_FETCH;
    unique case (state)
      S_FETCH:  state_nx = S_DECODE;
      S_DECODE: begin
        if      (opcode == OP_REG)  state_nx = S_RR_EX;
        else if (opcode == OP_ORI)  state_nx = S_OI_EX;
        else if (opcode == OP_LOAD) state_nx = S_LD_AD;
        else if (opcode == OP_STOR) state_nx = S_ST_AD;
        else if (opcode == OP_BEQ)  state_nx = eq_flag ? S_BR_TK : S_SEQ;
        else                        state_nx = S_SEQ;
      end
      S_RR_EX:  state_nx = S_RR_WB;
      S_OI_EX:  state_nx = S_OI_WB;
      S_LD_AD:  state_nx = S_LD_MEM;
      S_LD_MEM: state_nx = S_LD_WB;
      S_ST_AD:  state_nx = S_ST_MEM;
      default:  state_nx = S_FETCH;
    endcase
  end

  logic addr_calc;
  assign addr_calc = (state == S_LD_AD) || (state == S_ST_AD);

  assign phase    = state;
  assign imem_rd  = (state == S_FETCH);
  assign ir_load  = (state == S_FETCH);
  assign a_load   = (state == S_DECODE);
  assign b_load   = (state == S_DECODE);
  assign r_load   = addr_calc || (state == S_RR_EX) || (state == S_OI_EX);
  assign m_load   = (state == S_LD_MEM);
  assign pc_load  = (state == S_RR_WB) || (state == S_OI_WB) || (state == S_LD_WB) ||
                    (state == S_ST_MEM) || (state == S_BR_TK) || (state == S_SEQ);
  assign pc_src   = (state == S_BR_TK);
  assign dst_rd   = (state == S_RR_WB);
  assign reg_we   = (state == S_RR_WB) || (state == S_OI_WB) || (state == S_LD_WB);
  assign ext_sign = addr_calc;
  assign alu_imm  = addr_calc || (state == S_OI_EX);
  assign dmem_rd  = (state == S_LD_MEM);
  assign dmem_wr  = (state == S_ST_MEM);
  assign wb_mem   = (state == S_LD_WB);

  always_comb begin
    alu_fn = 6'h00;
    if (state == S_RR_EX)      alu_fn = funct;
    else if (state == S_OI_EX) alu_fn = FN_OR;
    else if (addr_calc)        alu_fn = FN_ADD;
  end

endmodule

// File: rtl/mc_ctrl_fsm_sva.sv
module mc_ctrl_fsm_sva (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] opcode,
  input logic [3:0] phase,
  input logic       reg_we,
  input logic       dmem_rd,
  input logic       dmem_wr,
  input logic       pc_load
);

  assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 4'b0000 |=> phase == 4'b0001);

  assert_load_dispatch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 4'b0001 && opcode == 6'h23) |=> phase == 4'b1000);

  assert_rr_sequence_R4: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 4'b0100 |=> phase == 4'b0101);

  assert_load_sequence_R6: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 4'b1001 |=> phase == 4'b1010);

  assert_single_access_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_we, dmem_rd, dmem_wr}));

  assert_pc_ends_instr_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> phase == 4'b0000);

  assert_no_unused_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= 4'b1100);

endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_sva chk_i (
  .clk(clk), .rst_n(rst_n), .opcode(opcode), .phase(phase),
  .reg_we(reg_we), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr), .pc_load(pc_load)
);

// File: tb/mc_ctrl_fsm_tb_top.sv
`timescale 1ns/1ps
module mc_ctrl_fsm_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] opcode = 6'h00, funct = 6'h00;
  logic eq_flag = 1'b0;
  logic [3:0] phase;
  logic imem_rd, ir_load, a_load, b_load, r_load, m_load, pc_load, pc_src;
  logic dst_rd, reg_we, ext_sign, alu_imm, dmem_rd, dmem_wr, wb_mem;
  logic [5:0] alu_fn;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  mc_ctrl_fsm dut_i (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct), .eq_flag(eq_flag),
    .phase(phase), .imem_rd(imem_rd), .ir_load(ir_load), .a_load(a_load),
    .b_load(b_load), .r_load(r_load), .m_load(m_load), .pc_load(pc_load),
    .pc_src(pc_src), .dst_rd(dst_rd), .reg_we(reg_we), .ext_sign(ext_sign),
    .alu_imm(alu_imm), .alu_fn(alu_fn), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
    .wb_mem(wb_mem)
  );

  // {opcode, funct, eq, length, path of five 4-bit states}
  localparam logic [35:0] VEC [8] = '{
    {6'h00, 6'h20, 1'b0, 3'd4, 20'h01450},
    {6'h00, 6'h22, 1'b1, 3'd4, 20'h01450},
    {6'h0D, 6'h11, 1'b0, 3'd4, 20'h01670},
    {6'h23, 6'h00, 1'b1, 3'd5, 20'h0189A},
    {6'h2B, 6'h00, 1'b0, 3'd4, 20'h01BC0},
    {6'h04, 6'h00, 1'b1, 3'd3, 20'h01200},
    {6'h04, 6'h00, 1'b0, 3'd3, 20'h01300},
    {6'h3F, 6'h00, 1'b1, 3'd3, 20'h01300}
  };

  function automatic string req_of(input logic [3:0] s);
    case (s)
      4'h0: req_of = "R1";  4'h1: req_of = "R2";
      4'h4, 4'h5: req_of = "R4"; 4'h6, 4'h7: req_of = "R5";
      4'h8, 4'h9, 4'hA: req_of = "R6"; 4'hB, 4'hC: req_of = "R7";
      default: req_of = "R8";
    endcase
  endfunction

  // {imem_rd,ir_load,a_load,b_load,r_load,m_load,pc_load,pc_src,dst_rd,reg_we,
  //  ext_sign,alu_imm,dmem_rd,dmem_wr,wb_mem,alu_fn}
  function automatic logic [20:0] exp_ctrl(input logic [3:0] s, input logic [5:0] fn);
    case (s)
      4'h0: exp_ctrl = {15'b110000000000000, 6'h00};
      4'h1: exp_ctrl = {15'b001100000000000, 6'h00};
      4'h4: exp_ctrl = {15'b000010000000000, fn};
      4'h5: exp_ctrl = {15'b000000101100000, 6'h00};
      4'h6: exp_ctrl = {15'b000010000001000, 6'h25};
      4'h7: exp_ctrl = {15'b000000100100000, 6'h00};
      4'h8, 4'hB: exp_ctrl = {15'b000010000011000, 6'h20};
      4'h9: exp_ctrl = {15'b000001000000100, 6'h00};
      4'hA: exp_ctrl = {15'b000000100100001, 6'h00};
      4'hC: exp_ctrl = {15'b000000100000010, 6'h00};
      4'h2: exp_ctrl = {15'b000000110000000, 6'h00};
      4'h3: exp_ctrl = {15'b000000100000000, 6'h00};
      default: exp_ctrl = '0;
    endcase
  endfunction

  function automatic logic [20:0] act_ctrl();
    act_ctrl = {imem_rd, ir_load, a_load, b_load, r_load, m_load, pc_load, pc_src,
                dst_rd, reg_we, ext_sign, alu_imm, dmem_rd, dmem_wr, wb_mem, alu_fn};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset phase", {28'd0, phase}, 32'd0);
    check("R1 reset outputs", {11'd0, act_ctrl()}, {11'd0, exp_ctrl(4'h0, 6'h00)});
    rst_n = 1'b1;
    check("R1 first cycle phase", {28'd0, phase}, 32'd0);

    for (int v = 0; v < 8; v++) begin
      logic [5:0] f;
      int len;
      f = VEC[v][29:24];
      len = int'(VEC[v][22:20]);
      opcode = VEC[v][35:30]; funct = f; eq_flag = VEC[v][23];
      for (int k = 0; k < len; k++) begin
        logic [3:0] s;
        s = VEC[v][19-4*k -: 4];
        check($sformatf("%s/R3 vec%0d step%0d phase", req_of(s), v, k), {28'd0, phase}, {28'd0, s});
        check($sformatf("%s vec%0d step%0d outputs", req_of(s), v, k),
              {11'd0, act_ctrl()}, {11'd0, exp_ctrl(s, f)});
        check("R12 exclusive strobes", $countones({reg_we, dmem_rd, dmem_wr}) <= 1, 32'd1);
        @(posedge clk); @(negedge clk);
        if (k == 1) begin
          // R10: scramble inputs after decode
          opcode = 6'h2B ^ opcode; eq_flag = ~eq_flag;
        end
      end
      check($sformatf("R11/R9 vec%0d back to fetch", v), {28'd0, phase}, 32'd0);
    end

    opcode = 6'h23; funct = 6'h00; eq_flag = 1'b0;
    repeat (3) @(negedge clk);
    check("R13 mid-load phase", {28'd0, phase}, 32'h9);
    rst_n = 1'b0;
    #1;
    check("R13 async reset phase", {28'd0, phase}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    check("R13 after release", {28'd0, phase}, 32'd0);
    @(negedge clk);
    check("R13 decode after release", {28'd0, phase}, 32'd1);
    finish_run();
  end
endmodule